// File: doc/BRIEF.md
# JTAG Scan Master

This block is the host side of a JTAG link. It generates TCK, TMS and TDI and reads TDO back. A single command port accepts four kinds of command:

- a TAP reset that ends in Run-Test/Idle;
- a move from Run-Test/Idle into Shift-IR;
- a move from Run-Test/Idle into Shift-DR;
- a scan of 1 to MAXBITS bits.

Each scan command carries three flags. One picks the bit order. One decides whether TMS rises on the final bit to leave the Shift state through Update. One decides whether a further cycle returns the TAP to Run-Test/Idle. A scan that does not leave the Shift state can be followed by another scan that continues the same register, so long registers are built from several commands.

The command port uses valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` stays low while a command is running, and that is the only back-pressure. A source may hold `cmd_valid` high with stable fields for as long as it likes. Fields are read only on the transfer edge. When a command completes, `done` pulses for one clock and the captured word appears on `result`.

Every TCK cycle lasts 2·HALF_CYC system clocks: HALF_CYC clocks low, then HALF_CYC clocks high. TCK rests high between commands.

Top module: `jtm_engine`

## Requirements
- R1: While reset is held and right after it is released, tck=1, tms=1, tdi=1, cmd_ready=1, done=0 and result=0.
- R2: A command transfers on a clock edge with cmd_valid and cmd_ready both high. cmd_ready is low from the next clock until the done cycle. Command fields that change after the transfer edge have no effect on the command in progress.
- R3: TCK idles high. Each TCK cycle is HALF_CYC clocks low followed by HALF_CYC clocks high. TMS and TDI change only as TCK falls while a command runs. A command of S TCK cycles shows done exactly 2·HALF_CYC·S clock edges after its transfer edge.
- R4: cmd_op=0 (TAP reset) gives six TCK cycles with TMS 1,1,1,1,1,0.
- R5: cmd_op=1 (to Shift-IR) gives four TCK cycles with TMS 1,1,0,0.
- R6: cmd_op=2 (to Shift-DR) gives three TCK cycles with TMS 1,0,0.
- R7: cmd_op=3 scans n=cmd_len+1 bits. With cmd_msb=0, TDI in data cycle i carries cmd_data[i].
- R8: With cmd_msb=1, TDI in data cycle i carries cmd_data[n-1-i].
- R9: With cmd_end=1, TMS is 1 in the last data cycle and one extra TCK cycle follows with TMS=1. If cmd_idle=1 as well, a second extra cycle follows with TMS=0. When cmd_end=0, cmd_idle has no effect.
- R10: With cmd_end=0, TMS is 0 in every data cycle and the scan has exactly n TCK cycles.
- R11: TDO is sampled on the last clock of each high phase during data cycles. The bit from data cycle i goes to result[i] when LSB-first and to result[n-1-i] when MSB-first. Result bits n and above read 0. result holds its value until the next scan command transfers.
- R12: TDI is 1 whenever cmd_ready is high and in every non-data TCK cycle.
- R13: done is high for exactly one clock, and cmd_ready is high in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine free to take a command |
| cmd_op | input | 2 | 0 TAP reset, 1 to Shift-IR, 2 to Shift-DR, 3 scan |
| cmd_len | input | clog2(MAXBITS) | Scan length minus one |
| cmd_msb | input | 1 | 1 = MSB-first scan |
| cmd_end | input | 1 | Leave the Shift state on the last bit |
| cmd_idle | input | 1 | After leaving, return to Run-Test/Idle |
| cmd_data | input | MAXBITS | Word to send |
| done | output | 1 | One-clock completion pulse |
| result | output | MAXBITS | Captured TDO word |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to target |
| tdo | input | 1 | Test data from target |

## Verification
The hardest case to reach from the ports is a scan whose last TDO bit is captured on the same clock edge that ends the command. On that edge the capture, the TDI return to 1 and the done pulse must all line up, and the bits above the scan length must stay cleared even though the sent word had them set. The stimulus reaches this case by sweeping every length from 1 to 32 in both bit orders under all four exit-flag combinations. A behavioural target drives a fresh TDO pattern on each falling TCK edge. After each transfer edge the stimulus scrambles the command fields, so a late read of the command port shows up as a wrong TDI bit.

// File: rtl/jtm_pkg.sv
package jtm_pkg;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_TO_IR = 2'd1,
    OP_TO_DR = 2'd2,
    OP_SHIFT = 2'd3
  } jtm_op_e;

  typedef struct packed {
    jtm_op_e op;
    logic    msb_first;
    logic    leave;
    logic    to_idle;
  } jtm_ctl_t;

endpackage

// File: rtl/jtm_phase_timer.sv
// Marks the last system clock of each TCK half-period.
module jtm_phase_timer #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic half_end
);
  generate
    if (HALF_CYC <= 1) begin : g_direct
      // One clock per half-period: every running clock ends a phase.
      assign half_end = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_CYC);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk) begin
        if (!rst_n || start) begin
          cnt_q <= '0;
        end else if (run) begin
          cnt_q <= (cnt_q == CW'(HALF_CYC - 1)) ? '0 : cnt_q + 1'b1;
        end
      end

      assign half_end = run && (cnt_q == CW'(HALF_CYC - 1));
    end
  endgenerate
endmodule

// File: rtl/jtm_step_plan.sv
// For a given TCK step index, works out the TMS level, whether the step
// carries a data bit, and whether the index lies past the command's end.
module jtm_step_plan
  import jtm_pkg::*;
#(
  parameter int LENW  = 5,
  parameter int STEPW = 6
) (
  input  jtm_op_e            op,
  input  logic               leave,
  input  logic               to_idle,
  input  logic [LENW-1:0]    len_m1,
  input  logic [STEPW-1:0]   step,
  output logic               tms_val,
  output logic               data_bit,
  output logic               beyond
);
  logic [STEPW-1:0] nbits;
  logic [STEPW-1:0] total;

  always_comb begin
    nbits    = STEPW'(len_m1) + 1'b1;
    tms_val  = 1'b0;
    data_bit = 1'b0;
    total    = '0;
    unique case (op)
      OP_RESET: begin
        total   = STEPW'(6);
        tms_val = (step < STEPW'(5));
      end
      OP_TO_IR: begin
        total   = STEPW'(4);
        tms_val = (step < STEPW'(2));
      end
      OP_TO_DR: begin
        total   = STEPW'(3);
        tms_val = (step == '0);
      end
      default: begin
        total    = nbits + STEPW'(leave) + STEPW'(leave & to_idle);
        data_bit = (step < nbits);
        if (data_bit) begin
          tms_val = leave && (step == nbits - 1'b1);
        end else begin
          // step nbits: Exit1 -> Update; step nbits+1: Update -> Idle
          tms_val = (step == nbits);
        end
      end
    endcase
    beyond = (step == total);
  end
endmodule

// File: rtl/jtm_scan_reg.sv
// Data shift register: sends one bit per data step and captures TDO into
// the position that matches the transmit order.
module jtm_scan_reg #(
  parameter int W    = 32,
  parameter int LENW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [W-1:0]    ld_data,
  input  logic [LENW-1:0] ld_len,
  input  logic            ld_msb,
  input  logic            shift_en,
  input  logic [LENW-1:0] len_m1,
  input  logic            msb_first,
  input  logic            tdo_in,
  output logic            first_bit,
  output logic            next_bit,
  output logic [W-1:0]    word
);
  logic [W-1:0] sh_q;
  logic [W-1:0] nxt;
  logic [W-1:0] ld_word;
  logic [W-1:0] run_mask;

  always_comb begin
    ld_word   = ld_data & ({W{1'b1}} >> (W - 1 - int'(ld_len)));
    run_mask  = {W{1'b1}} >> (W - 1 - int'(len_m1));
    first_bit = ld_msb ? ld_word[ld_len] : ld_word[0];
    if (msb_first) begin
      nxt = ((sh_q << 1) | W'(tdo_in)) & run_mask;
    end else begin
      nxt         = sh_q >> 1;
      nxt[len_m1] = tdo_in;
    end
    next_bit = msb_first ? nxt[len_m1] : nxt[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load) begin
      sh_q <= ld_word;
    end else if (shift_en) begin
      sh_q <= nxt;
    end
  end

  assign word = sh_q;
endmodule

// File: rtl/jtm_engine.sv
module jtm_engine
  import jtm_pkg::*;
#(
  parameter int MAXBITS  = 32,
  parameter int HALF_CYC = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(MAXBITS)-1:0] cmd_len,
  input  logic                       cmd_msb,
  input  logic                       cmd_end,
  input  logic                       cmd_idle,
  input  logic [MAXBITS-1:0]         cmd_data,
  output logic                       done,
  output logic [MAXBITS-1:0]         result,
  output logic                       tck,
  output logic                       tms,
  output logic                       tdi,
  input  logic                       tdo
);
  localparam int LENW  = $clog2(MAXBITS);
  localparam int STEPW = $clog2(MAXBITS + 3);

  logic             busy_q;
  logic [STEPW-1:0] step_q;
  jtm_ctl_t         ctl_q;
  logic [LENW-1:0]  len_q;
  logic             tck_q, tms_q, tdi_q, done_q;

  logic             accept;
  logic             half_end;
  logic [STEPW-1:0] step_nx;
  logic             nx_tms, nx_data, nx_beyond;
  logic             cur_data;
  logic             first_bit, next_bit;
  logic             first_tms, first_tdi;
  logic             is_shift_cmd;
  jtm_ctl_t         cmd_ctl;

  assign accept       = cmd_valid && !busy_q;
  assign is_shift_cmd = (cmd_op == OP_SHIFT);
  assign cmd_ctl      = '{op: jtm_op_e'(cmd_op), msb_first: cmd_msb,
                          leave: cmd_end, to_idle: cmd_idle};
  assign step_nx      = step_q + 1'b1;
  assign cur_data     = (ctl_q.op == OP_SHIFT) && (step_q <= STEPW'(len_q));

  // First TCK cycle of a command is set up straight from the command port.
  assign first_tms = !is_shift_cmd || (cmd_end && (cmd_len == '0));
  assign first_tdi = is_shift_cmd ? first_bit : 1'b1;

  jtm_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .run      (busy_q),
    .half_end (half_end)
  );

  // Looks one step ahead so the next TMS/TDI are ready at the falling edge.
  jtm_step_plan #(.LENW(LENW), .STEPW(STEPW)) u_plan (
    .op       (ctl_q.op),
    .leave    (ctl_q.leave),
    .to_idle  (ctl_q.to_idle),
    .len_m1   (len_q),
    .step     (step_nx),
    .tms_val  (nx_tms),
    .data_bit (nx_data),
    .beyond   (nx_beyond)
  );

  jtm_scan_reg #(.W(MAXBITS), .LENW(LENW)) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && is_shift_cmd),
    .ld_data   (cmd_data),
    .ld_len    (cmd_len),
    .ld_msb    (cmd_msb),
    .shift_en  (busy_q && tck_q && half_end && cur_data),
    .len_m1    (len_q),
    .msb_first (ctl_q.msb_first),
    .tdo_in    (tdo),
    .first_bit (first_bit),
    .next_bit  (next_bit),
    .word      (result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      ctl_q  <= '{op: OP_RESET, msb_first: 1'b0, leave: 1'b0, to_idle: 1'b0};
      len_q  <= '0;
      tck_q  <= 1'b1;
      tms_q  <= 1'b1;
      tdi_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        step_q <= '0;
        ctl_q  <= cmd_ctl;
        len_q  <= cmd_len;
        tck_q  <= 1'b0;
        tms_q  <= first_tms;
        tdi_q  <= first_tdi;
      end else if (busy_q && half_end) begin
        if (!tck_q) begin
          tck_q <= 1'b1;
        end else if (nx_beyond) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          tdi_q  <= 1'b1;
        end else begin
          step_q <= step_nx;
          tck_q  <= 1'b0;
          tms_q  <= nx_tms;
          tdi_q  <= nx_data ? next_bit : 1'b1;
        end
      end
    end
  end

  assign cmd_ready = !busy_q;
  assign done      = done_q;
  assign tck       = tck_q;
  assign tms       = tms_q;
  assign tdi       = tdi_q;
endmodule

// File: rtl/jtm_engine_chk.sv
module jtm_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic done,
  input logic tck,
  input logic tms,
  input logic tdi
);
  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  a_r3_idle_tck_high: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> tck);

  a_r3_fall_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tck) |-> !cmd_ready);

  a_r3_steady_in_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tck && $past(tck) && !cmd_ready) |-> ($stable(tms) && $stable(tdi)));

  a_r12_tdi_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> tdi);

  a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r13_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
endmodule

bind jtm_engine jtm_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .done      (done),
  .tck       (tck),
  .tms       (tms),
  .tdi       (tdi)
);

// File: tb/tb_jtm_engine.sv
module tb_jtm_engine;
  localparam int MAXBITS = 32;
  localparam int HALF    = 2;
  localparam int LENW    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic               cmd_valid = 1'b0;
  logic               cmd_ready;
  logic [1:0]         cmd_op = 2'd0;
  logic [LENW-1:0]    cmd_len = '0;
  logic               cmd_msb = 1'b0, cmd_end = 1'b0, cmd_idle = 1'b0;
  logic [MAXBITS-1:0] cmd_data = '0;
  logic               done;
  logic [MAXBITS-1:0] result;
  logic               tck, tms, tdi;
  logic               tdo = 1'b0;

  jtm_engine #(.MAXBITS(MAXBITS), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_len(cmd_len), .cmd_msb(cmd_msb), .cmd_end(cmd_end),
    .cmd_idle(cmd_idle), .cmd_data(cmd_data), .done(done), .result(result),
    .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Target model: record TMS/TDI on rising TCK, drive TDO on falling TCK.
  int k = 0;
  int start = 0;
  logic [63:0] rec_tms = '0, rec_tdi = '0, tdo_pat = '0;

  always @(posedge tck) begin
    rec_tms[k & 63] <= tms;
    rec_tdi[k & 63] <= tdi;
    k <= k + 1;
  end

  always @(negedge tck) tdo <= tdo_pat[(k - start) & 63];

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog actual=%h expected=%h", 64'd0, 64'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic run_cmd(input logic [1:0] op, input int n, input bit msb,
                         input bit en, input bit idl, input logic [31:0] data,
                         input logic [63:0] pat, output int steps,
                         output int cyc, output logic [63:0] tms_v,
                         output logic [63:0] tdi_v);
    @(negedge clk);
    start   = k;
    tdo_pat = pat;
    cmd_op  = op; cmd_len = LENW'(n - 1); cmd_msb = msb;
    cmd_end = en; cmd_idle = idl; cmd_data = data; cmd_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    // R2: scramble the fields after transfer
    cmd_op = ~op; cmd_msb = ~msb; cmd_end = ~en; cmd_idle = ~idl;
    cmd_data = ~data; cmd_len = ~cmd_len;
    chk(!cmd_ready, "R2 ready low while busy", 64'(cmd_ready), 64'd0);
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cmd_ready, "R13 ready with done", 64'(cmd_ready), 64'd1);
    steps = k - start;
    tms_v = '0; tdi_v = '0;
    for (int i = 0; i < steps && i < 64; i++) begin
      tms_v[i] = rec_tms[(start + i) & 63];
      tdi_v[i] = rec_tdi[(start + i) & 63];
    end
    @(negedge clk);
    chk(!done, "R13 done one clock", 64'(done), 64'd0);
    chk(tdi && tck, "R12 tdi/tck rest high", {62'd0, tdi, tck}, 64'd3);
  endtask

  initial begin
    int steps, cyc;
    logic [63:0] tv, dv;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(tck && tms && tdi && cmd_ready && !done && result == '0,
        "R1 state in reset", {58'd0, tck, tms, tdi, cmd_ready, done, |result},
        64'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tck && tms && tdi && cmd_ready && !done && result == '0,
        "R1 state after reset", {58'd0, tck, tms, tdi, cmd_ready, done, |result},
        64'b111100);

    // R4 TAP reset
    run_cmd(2'd0, 1, 0, 0, 0, 32'h0, 64'h0, steps, cyc, tv, dv);
    chk(steps == 6 && tv == 64'h1F, "R4 reset TMS", tv, 64'h1F);
    chk(dv == 64'h3F, "R12 tdi high in reset", dv, 64'h3F);
    chk(cyc == 2 * HALF * 6, "R3 reset timing", 64'(cyc), 64'(2 * HALF * 6));

    // R5 to Shift-IR
    run_cmd(2'd1, 1, 0, 0, 0, 32'h0, 64'h0, steps, cyc, tv, dv);
    chk(steps == 4 && tv == 64'h3, "R5 IR TMS", tv, 64'h3);
    chk(cyc == 2 * HALF * 4, "R3 IR timing", 64'(cyc), 64'(2 * HALF * 4));

    // R6 to Shift-DR
    run_cmd(2'd2, 1, 0, 0, 0, 32'h0, 64'h0, steps, cyc, tv, dv);
    chk(steps == 3 && tv == 64'h1, "R6 DR TMS", tv, 64'h1);
    chk(dv == 64'h7, "R12 tdi high in DR move", dv, 64'h7);

    // Sweep: every length, both orders, all exit flag combinations
    for (int m = 0; m < 2; m++) begin
      for (int fl = 0; fl < 4; fl++) begin
        for (int n = 1; n <= 32; n++) begin
          bit en, idl;
          int s;
          logic [31:0] data, rexp;
          logic [63:0] pat, texp, dexp;
          en   = fl[0];
          idl  = fl[1];
          data = 32'h9E37_79B9 * 32'(n + 40 * fl + 200 * m) + 32'h0123_4567;
          pat  = {data * 32'd3, ~data} ^ 64'(n * 7);
          s    = n + (en ? 1 : 0) + ((en && idl) ? 1 : 0);
          texp = '0; dexp = '0; rexp = '0;
          for (int i = 0; i < s; i++) begin
            if (i < n) begin
              texp[i] = en && (i == n - 1);
              dexp[i] = (m == 1) ? data[n - 1 - i] : data[i];
              if (m == 1) rexp[n - 1 - i] = pat[i];
              else        rexp[i] = pat[i];
            end else begin
              texp[i] = (i == n);
              dexp[i] = 1'b1;
            end
          end
          run_cmd(2'd3, n, m[0], en, idl, data, pat, steps, cyc, tv, dv);
          // R9 / R10: cycle count and TMS pattern
          chk(steps == s, en ? "R9 step count" : "R10 step count",
              64'(steps), 64'(s));
          chk(tv == texp, en ? "R9 TMS pattern" : "R10 TMS pattern", tv, texp);
          chk(dv == dexp, (m == 1) ? "R8 TDI MSB-first" : "R7 TDI LSB-first",
              dv, dexp);
          chk(result == rexp, "R11 captured word", 64'(result), 64'(rexp));
          chk(cyc == 2 * HALF * s, "R3 scan timing", 64'(cyc), 64'(2 * HALF * s));
        end
      end
    end

    // R11: a non-scan command leaves result untouched
    held = result;
    run_cmd(2'd2, 1, 0, 0, 0, 32'hFFFF_FFFF, 64'hFFFF, steps, cyc, tv, dv);
    chk(result == held, "R11 result held", 64'(result), 64'(held));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule